// File: doc/BRIEF.md
# Pulse-Driven Gate Enable Latch with Starvation Watchdog

This block sits on the receive side of one isolated signalling channel. The transmit side sends a short "set" pulse when its input rises, a short "clear" pulse when it falls, and repeats the pulse for the current level at a regular refresh rate while the input is steady. The block turns those pulses back into a steady level, `gate_en`, which enables a gate driver stage.

Several conditions force `gate_en` low. The first is pulse starvation: no usable pulse within a programmable number of clock cycles, which means the far side is unpowered or broken. The second is a low local supply-good input. The third is an active over-temperature flag. The supply and temperature comparators, including their hysteresis, are analog and live outside the block; they arrive here as plain digital levels. After local supply recovery, and after reset, a start-up hold-off keeps the output low for a set number of cycles.

Each fault clears the stored level. So once the fault goes away, the output stays low until a fresh set pulse arrives. In normal operation that is at most one refresh interval later. A status output reports a watchdog timeout until the next usable pulse.

Top module: `gate_latch_guard`

## Requirements
- R1: While `rst_n` is low, and right after its release, `gate_en` and `wd_expired` are both low.
- R2: A valid set pulse (`set_pls`=1, `clr_pls`=0) with no fault active makes `gate_en` high after that clock edge. A valid clear pulse (`clr_pls`=1, `set_pls`=0) makes it low after that edge.
- R3: In cycles with no pulse, `gate_en` keeps its previous value unless a fault or a timeout forces it low.
- R4: A cycle with both pulse lines high is treated as no pulse. It does not change `gate_en`, does not restart the watchdog and does not clear `wd_expired`.
- R5: Suppose WD_CYCLES consecutive clock edges follow the last valid pulse, none of them carrying a valid pulse. Then at the last of those edges `gate_en` goes low and `wd_expired` goes high.
- R6: `wd_expired` clears at the edge that takes the next valid pulse. A set pulse at that edge also drives `gate_en` high.
- R7: While `supply_ok` is low, `gate_en` is low from the following edge on, and set pulses are ignored.
- R8: After `supply_ok` rises, and after reset, set pulses are ignored at the first HOLD_CYCLES edges with `supply_ok` high. A set pulse at edge HOLD_CYCLES+1 is accepted.
- R9: While `overtemp` is high, `gate_en` is low from the following edge on, and set pulses are ignored.
- R10: After a timeout, supply fault or over-temperature condition ends, `gate_en` stays low through idle cycles until a valid set pulse is accepted.
- R11: Every valid pulse restarts the watchdog, including a refresh pulse that repeats the current level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| set_pls | input | 1 | One-cycle set pulse from the decoder front end |
| clr_pls | input | 1 | One-cycle clear pulse from the decoder front end |
| supply_ok | input | 1 | Local supply-good level, high when the supply is above its lockout threshold |
| overtemp | input | 1 | Over-temperature flag, high forces the output low |
| gate_en | output | 1 | Registered gate drive enable |
| wd_expired | output | 1 | High after a pulse-starvation timeout until the next valid pulse |

## Verification
Every result in this block is registered one edge deep. A pulse, a supply drop or an over-temperature level shows on `gate_en` right after the clock edge that samples it. A timeout shows after the WD_CYCLES-th idle edge following the last valid pulse. The hold-off ends so that the pulse at edge HOLD_CYCLES+1 with supply good is the first one accepted. The bench changes inputs on the falling edge and reads the outputs one time unit after the next rising edge, so each check sees exactly the edge it predicts. It sweeps the idle gap length on both sides of the timeout and works out the expected level and status from the gap length alone.

// File: rtl/gate_latch_pkg.sv
package gate_latch_pkg;

  typedef enum logic [1:0] {
    PK_NONE = 2'b00,
    PK_SET  = 2'b01,
    PK_CLR  = 2'b10,
    PK_BOTH = 2'b11
  } pulse_kind_t;

  function automatic pulse_kind_t classify_pulse(input logic s, input logic c);
    pulse_kind_t k;
    unique case ({c, s})
      2'b01:   k = PK_SET;
      2'b10:   k = PK_CLR;
      2'b11:   k = PK_BOTH;
      default: k = PK_NONE;
    endcase
    return k;
  endfunction

  function automatic logic is_usable(input pulse_kind_t k);
    return (k == PK_SET) || (k == PK_CLR);
  endfunction

endpackage

// File: rtl/starve_timer.sv
module starve_timer #(
  parameter int unsigned WD_CYCLES = 375
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic fire,
  output logic expired
);
  localparam int unsigned CW = $clog2(WD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WD_CYCLES - 1);
  localparam logic [CW-1:0] SAT  = CW'(WD_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          exp_q, exp_d;

  // The timeout fires once, on the idle edge that completes the window.
  assign fire = !kick && (cnt_q == LAST);

  always_comb begin
    cnt_en = kick || (cnt_q != SAT);
    cnt_d  = kick ? '0 : cnt_q + 1'b1;
    if (kick)      exp_d = 1'b0;
    else if (fire) exp_d = 1'b1;
    else           exp_d = exp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expired = exp_q;
endmodule

// File: rtl/startup_holdoff.sv
module startup_holdoff #(
  parameter int unsigned HOLD_CYCLES = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic ready
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] DONE = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = !supply_ok || (cnt_q != DONE);
    cnt_d  = supply_ok ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == DONE);
endmodule

// File: rtl/drive_latch.sv
module drive_latch
  import gate_latch_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  pulse_kind_t kind,
  input  logic        block,
  input  logic        starve,
  output logic        level
);
  logic lvl_q, lvl_d;

  always_comb begin
    if (block || starve) begin
      lvl_d = 1'b0;
    end else begin
      unique case (kind)
        PK_SET:  lvl_d = 1'b1;
        PK_CLR:  lvl_d = 1'b0;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign level = lvl_q;
endmodule

// File: rtl/gate_latch_guard.sv
module gate_latch_guard
  import gate_latch_pkg::*;
#(
  parameter int unsigned WD_CYCLES   = 375,
  parameter int unsigned HOLD_CYCLES = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pls,
  input  logic clr_pls,
  input  logic supply_ok,
  input  logic overtemp,
  output logic gate_en,
  output logic wd_expired
);
  pulse_kind_t kind;
  logic        kick;
  logic        starve;
  logic        hold_ready;
  logic        block;

  assign kind  = classify_pulse(set_pls, clr_pls);
  assign kick  = is_usable(kind);
  assign block = !supply_ok || overtemp || !hold_ready;

  starve_timer #(.WD_CYCLES(WD_CYCLES)) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .kick    (kick),
    .fire    (starve),
    .expired (wd_expired)
  );

  startup_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .ready     (hold_ready)
  );

  drive_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind   (kind),
    .block  (block),
    .starve (starve),
    .level  (gate_en)
  );
endmodule

// File: rtl/gate_latch_guard_chk.sv
module gate_latch_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic set_pls,
  input logic clr_pls,
  input logic supply_ok,
  input logic overtemp,
  input logic hold_ready,
  input logic gate_en,
  input logic wd_expired
);
  p_set_drives_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pls && !clr_pls && supply_ok && !overtemp && hold_ready) |=> gate_en);

  p_clr_drives_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pls && !set_pls) |=> !gate_en);

  p_pair_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pls && clr_pls) |=> (!gate_en || $past(gate_en)));

  p_rise_needs_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> $past(set_pls && !clr_pls));

  p_expired_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expired |-> !gate_en);

  p_expire_only_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_expired) |-> $past(!(set_pls ^ clr_pls)));

  p_supply_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !gate_en);

  p_overtemp_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overtemp |=> !gate_en);

  p_clear_on_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pls ^ clr_pls) |=> !wd_expired);
endmodule

bind gate_latch_guard gate_latch_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .set_pls    (set_pls),
  .clr_pls    (clr_pls),
  .supply_ok  (supply_ok),
  .overtemp   (overtemp),
  .hold_ready (hold_ready),
  .gate_en    (gate_en),
  .wd_expired (wd_expired)
);

// File: tb/gate_latch_guard_bench.sv
module gate_latch_guard_bench;
  localparam int W = 8;
  localparam int S = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic set_pls, clr_pls, supply_ok, overtemp;
  logic gate_en, wd_expired;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  gate_latch_guard #(.WD_CYCLES(W), .HOLD_CYCLES(S)) u_gate_latch_guard (
    .clk(clk), .rst_n(rst_n), .set_pls(set_pls), .clr_pls(clr_pls),
    .supply_ok(supply_ok), .overtemp(overtemp),
    .gate_en(gate_en), .wd_expired(wd_expired)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic c, input logic sup, input logic ot);
    @(negedge clk);
    set_pls = s; clr_pls = c; supply_ok = sup; overtemp = ot;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; set_pls = 1'b0; clr_pls = 1'b0; supply_ok = 1'b1; overtemp = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 gate_en in reset", gate_en, 1'b0);
    chk("R1 wd_expired in reset", wd_expired, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 gate_en after release", gate_en, 1'b0);
    chk("R1 wd_expired after release", wd_expired, 1'b0);

    // R8: hold-off after reset; first edge above was idle
    for (int k = 1; k <= S; k++) begin
      step(1, 0, 1, 0);
      chk("R8 holdoff after reset", gate_en, (k == S));
    end

    // R3 hold high, R2 clear and set
    repeat (3) step(0, 0, 1, 0);
    chk("R3 hold high", gate_en, 1'b1);
    step(0, 1, 1, 0);
    chk("R2 clear pulse", gate_en, 1'b0);
    repeat (3) step(0, 0, 1, 0);
    chk("R3 hold low", gate_en, 1'b0);
    step(1, 1, 1, 0);
    chk("R4 pair while low", gate_en, 1'b0);
    step(1, 0, 1, 0);
    chk("R2 set pulse", gate_en, 1'b1);

    // R4: pairs neither change level nor restart watchdog
    for (int k = 1; k < W; k++) step(1, 1, 1, 0);
    chk("R4 pair while high", gate_en, 1'b1);
    chk("R4 no timeout yet", wd_expired, 1'b0);
    step(0, 0, 1, 0);
    chk("R4 pair did not kick, gate", gate_en, 1'b0);
    chk("R4 pair did not kick, status", wd_expired, 1'b1);
    step(1, 1, 1, 0);
    chk("R4 pair keeps status", wd_expired, 1'b1);

    // R6: clear pulse clears status; set pulse clears and raises
    step(0, 1, 1, 0);
    chk("R6 clear pulse drops status", wd_expired, 1'b0);
    chk("R6 clear pulse level", gate_en, 1'b0);
    step(1, 0, 1, 0);
    chk("R2 set after clear", gate_en, 1'b1);

    // R11: refresh pulse at edge W keeps level alive
    for (int k = 1; k < W; k++) step(0, 0, 1, 0);
    step(1, 0, 1, 0);
    chk("R11 refresh restarts watchdog", gate_en, 1'b1);
    chk("R11 no status after refresh", wd_expired, 1'b0);
    for (int k = 1; k < W; k++) step(0, 0, 1, 0);
    chk("R11 window restarted", gate_en, 1'b1);
    step(0, 0, 1, 0);
    chk("R5 timeout level", gate_en, 1'b0);
    chk("R5 timeout status", wd_expired, 1'b1);
    repeat (4) step(0, 0, 1, 0);
    chk("R10 stays low after timeout", gate_en, 1'b0);
    chk("R5 status held", wd_expired, 1'b1);
    step(1, 0, 1, 0);
    chk("R6 set clears status", wd_expired, 1'b0);
    chk("R6 set after timeout", gate_en, 1'b1);

    // R5/R11 sweep over idle gap length
    for (int g = 1; g <= W + 3; g++) begin
      step(1, 0, 1, 0);
      chk("R11 sweep set", gate_en, 1'b1);
      for (int k = 0; k < g; k++) step(0, 0, 1, 0);
      chk("R5 sweep level", gate_en, (g < W) ? 1'b1 : 1'b0);
      chk("R5 sweep status", wd_expired, (g >= W) ? 1'b1 : 1'b0);
    end
    step(1, 0, 1, 0);
    chk("R6 recover after sweep", gate_en, 1'b1);

    // R7: supply low forces low, sets ignored
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 0, 0);
      chk("R7 supply low", gate_en, 1'b0);
    end
    for (int k = 1; k <= S + 1; k++) begin
      step(1, 0, 1, 0);
      chk("R8 holdoff after supply", gate_en, (k == S + 1));
    end
    // supply fault again, then idle recovery
    repeat (2) step(1, 0, 0, 0);
    for (int k = 1; k <= S + 1; k++) begin
      step(0, 0, 1, 0);
      chk("R10 idle after supply fault", gate_en, 1'b0);
    end
    step(1, 0, 1, 0);
    chk("R10 set after supply fault", gate_en, 1'b1);

    // R9: over-temperature
    for (int k = 0; k < 3; k++) begin
      step(1, 0, 1, 1);
      chk("R9 overtemp", gate_en, 1'b0);
    end
    repeat (3) step(0, 0, 1, 0);
    chk("R10 idle after overtemp", gate_en, 1'b0);
    step(1, 0, 1, 0);
    chk("R10 set after overtemp", gate_en, 1'b1);
    chk("R6 no status after overtemp", wd_expired, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule